// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page-table entries from a word-wide memory, one after the other. A requester presents a virtual address together with the current table root. The walker uses the top ten bits of the address to select an entry in the root table. If that entry is marked present, its frame field gives the base of a second table. The next ten bits then select an entry in that table, and the frame field of that entry is combined with the untouched 12-bit page offset to form the result.

When either entry is marked absent, the walker answers with a fault instead of an address and reports which level failed. If the first level fails, the second read is never issued. The requester side uses a valid/ready request and a valid/ready response, and the response is held until it is taken. The memory side is one read port: the walker holds a read request and its address until the memory raises its ready signal, and that signal may take any number of cycles to arrive. The data is sampled in the cycle in which ready is high.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `resp_valid` and `mem_rd_valid` are 0.
- R2: The first read goes to address `{root[31:12], 12'h000} + 4 * vaddr[31:22]`. Bits 11:0 of `root` are ignored.
- R3: The second read goes to address `{e1[31:12], 12'h000} + 4 * vaddr[21:12]`, where `e1` is the first entry returned.
- R4: When both entries have bit 0 set, the response carries `resp_fault` = 0 and `resp_paddr = {e2[31:12], vaddr[11:0]}`. Entry bits 11:1 are ignored.
- R5: When `e1` bit 0 is 0, the response has `resp_fault` = 1 and `resp_fault_lvl` = 0, and only one memory read is issued.
- R6: When `e1` is valid but `e2` bit 0 is 0, the response has `resp_fault` = 1 and `resp_fault_lvl` = 1, after two reads.
- R7: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address stay unchanged in the next cycle.
- R8: `resp_valid` and every response field stay unchanged until `resp_ready` is seen. After that handshake the walker is idle again.
- R9: A new request is accepted only when idle. While a walk or a response is pending, `req_ready` is 0, and changes on `req_vaddr` or `root` have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request taken when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| root | input | 32 | Root table base, bits 31:12 used, sampled at acceptance |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Requester takes the response |
| resp_paddr | output | 32 | Physical address (meaningful when no fault) |
| resp_fault | output | 1 | Page fault: an entry was not present |
| resp_fault_lvl | output | 1 | Failing level: 0 first, 1 second |
| mem_rd_valid | output | 1 | Read request to table memory |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_ready | input | 1 | Read completes; data valid this cycle |
| mem_rd_data | input | 32 | Entry read from memory |

## Verification
The assertions assume that the memory raises `mem_rd_ready` only while a read is outstanding, and that it drives `mem_rd_data` in that same cycle. They also assume that the requester lowers `resp_ready` except when it means to take a response. The bench's memory model sees a read only when `mem_rd_valid` is high, pulses ready for a single cycle after a latency chosen for each vector, and returns the entry only in that cycle. Response acceptance is delayed on purpose so that the hold rules are actually exercised.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]       req_vaddr,
  input  logic [2*IDX_W+OFF_W-1:0]       root,
  output logic                           resp_valid,
  input  logic                           resp_ready,
  output logic [2*IDX_W+OFF_W-1:0]       resp_paddr,
  output logic                           resp_fault,
  output logic                           resp_fault_lvl,
  output logic                           mem_rd_valid,
  output logic [2*IDX_W+OFF_W-1:0]       mem_rd_addr,
  input  logic                           mem_rd_ready,
  input  logic [2*IDX_W+OFF_W-1:0]       mem_rd_data
);
  localparam int VA_W    = 2*IDX_W + OFF_W;
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int PAD_W   = VA_W - IDX_W - 2;

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_L1   = 2'd1;
  localparam logic [1:0] S_L2   = 2'd2;
  localparam logic [1:0] S_RESP = 2'd3;

  logic [1:0]         st;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] base_q;
  logic [VA_W-1:0]    paddr_q;
  logic               fault_q, lvl_q;
  logic [IDX_W-1:0]   idx;
  logic               hit;

  assign idx  = (st == S_L1) ? va_q[VA_W-1 -: IDX_W] : va_q[OFF_W +: IDX_W];
  assign hit  = mem_rd_valid && mem_rd_ready;

  assign req_ready      = (st == S_IDLE);
  assign mem_rd_valid   = (st == S_L1) || (st == S_L2);
  assign mem_rd_addr    = {base_q, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, 2'b00};
  assign resp_valid     = (st == S_RESP);
  assign resp_paddr     = paddr_q;
  assign resp_fault     = fault_q;
  assign resp_fault_lvl = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= root[VA_W-1:OFF_W];
          st     <= S_L1;
        end
        S_L1: if (hit) begin
          if (mem_rd_data[0]) begin
            base_q <= mem_rd_data[VA_W-1:OFF_W];
            st     <= S_L2;
          end else begin
            fault_q <= 1'b1;
            lvl_q   <= 1'b0;
            paddr_q <= '0;
            st      <= S_RESP;
          end
        end
        S_L2: if (hit) begin
          fault_q <= ~mem_rd_data[0];
          lvl_q   <= 1'b1;
          paddr_q <= mem_rd_data[0] ? {mem_rd_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
          st      <= S_RESP;
        end
        default: if (resp_ready) begin
          fault_q <= 1'b0;
          lvl_q   <= 1'b0;
          st      <= S_IDLE;
        end
      endcase
    end
  end

  p_idle_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !resp_valid && !mem_rd_valid);

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_resp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr)
      && $stable(resp_fault) && $stable(resp_fault_lvl));

  p_resp_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready |=> req_ready);

  p_l1_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_L1 && hit && !mem_rd_data[0] |=> resp_valid && resp_fault
      && !resp_fault_lvl && !mem_rd_valid);

  p_l2_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_L2 && hit && mem_rd_data[0] |=> resp_valid && !resp_fault
      && resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

  p_l2_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_L2 && hit && !mem_rd_data[0] |=> resp_valid && resp_fault && resp_fault_lvl);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic        resp_fault_lvl;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .root(root),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_VA [NV] = '{32'h0040_1ABC, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678,
                                        32'h8765_4321, 32'h3FF0_0123, 32'hC000_3FFF, 32'h0000_0000};
  localparam logic [31:0] V_RT [NV] = '{32'h0010_0000, 32'h0030_0FFF, 32'h0000_0000, 32'h0040_0000,
                                        32'h0080_0000, 32'h0100_0000, 32'hFFFF_F000, 32'h0000_0000};
  localparam logic [31:0] V_E1 [NV] = '{32'h0020_0001, 32'h0050_0003, 32'h0001_0001, 32'hDEAD_B000,
                                        32'h0090_0001, 32'h0200_0001, 32'h1111_1001, 32'hFFFF_FFFE};
  localparam logic [31:0] V_E2 [NV] = '{32'h0ABC_D001, 32'hFFFF_F001, 32'h0002_0001, 32'h0000_0000,
                                        32'h7777_7FFE, 32'h0300_0FFF, 32'h2222_2001, 32'h0000_0001};
  localparam int V_LAT [NV] = '{0, 3, 1, 2, 4, 7, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] rt, input logic [31:0] e1,
                      input logic [31:0] e2, input int lat);
    logic [31:0] a1, a2, last, pa;
    int reads, waitc;
    bit got, f1, f2;
    a1 = {rt[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
    a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    f1 = !e1[0];
    f2 = e1[0] && !e2[0];
    pa = {e2[31:12], va[11:0]};
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle before request", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_vaddr = va; root = rt;
    @(negedge clk);
    req_vaddr = ~va; root = ~rt;
    reads = 0; waitc = 0; got = 0; last = '0;
    for (int c = 0; c < 60 && !got; c++) begin
      mem_rd_ready = 1'b0;
      mem_rd_data  = 32'h5A5A_5A5A;
      if (resp_valid) begin
        got = 1;
      end else begin
        chk(req_ready == 1'b0, "R9 busy blocks request", {31'h0, req_ready}, 32'h0);
        if (mem_rd_valid) begin
          if (waitc == 0)
            chk(mem_rd_addr == (reads == 0 ? a1 : a2), reads == 0 ? "R2 first address" : "R3 second address",
                mem_rd_addr, reads == 0 ? a1 : a2);
          else
            chk(mem_rd_addr == last, "R7 address held", mem_rd_addr, last);
          last = mem_rd_addr;
          if (waitc == lat) begin
            mem_rd_ready = 1'b1;
            mem_rd_data  = (reads == 0) ? e1 : e2;
            reads++;
            waitc = 0;
          end else begin
            waitc++;
          end
        end
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    chk(got, "R8 response arrives", {31'h0, got}, 32'h1);
    chk(reads == (f1 ? 1 : 2), f1 ? "R5 single read on first fault" : "R6 two reads", reads, f1 ? 1 : 2);
    chk(resp_fault == (f1 || f2), f1 ? "R5 fault flag" : (f2 ? "R6 fault flag" : "R4 no fault"),
        {31'h0, resp_fault}, {31'h0, f1 || f2});
    if (f1 || f2)
      chk(resp_fault_lvl == f2, f1 ? "R5 fault level" : "R6 fault level", {31'h0, resp_fault_lvl}, {31'h0, f2});
    else
      chk(resp_paddr == pa, "R4 physical address", resp_paddr, pa);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk(resp_valid && resp_paddr == (f1 || f2 ? resp_paddr : pa), "R8 response held", resp_paddr, pa);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, "R8 idle after handshake", {30'h0, resp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_valid, "R1 reset state",
        {29'h0, req_ready, resp_valid, mem_rd_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_valid, "R1 idle after reset release",
        {29'h0, req_ready, resp_valid, mem_rd_valid}, 32'h4);
    for (int v = 0; v < NV; v++)
      walk(V_VA[v], V_RT[v], V_E1[v], V_E2[v], V_LAT[v]);
    // R3 corner: second-level table at top of memory, last index
    walk(32'h003F_F000, 32'h0000_0000, 32'hFFFF_F001, 32'h0000_1001, 5);
    // R9 corner: idle with no request stays idle
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_valid, "R9 no request no read", {30'h0, req_ready, mem_rd_valid}, 32'h2);
    // R1 reset mid-walk returns to idle
    req_valid = 1'b1; req_vaddr = 32'h0123_4567; root = 32'h0100_0000;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_rd_valid && !resp_valid, "R1 reset during walk",
        {29'h0, req_ready, resp_valid, mem_rd_valid}, 32'h4);
    rst_n = 1'b1;
    walk(32'h0000_2345, 32'h0000_3000, 32'h0000_4001, 32'h0000_5001, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule